// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Pin Emulator

This block is a synthesizable stand-in for a byte-wide ultraviolet-erasable, one-time-programmable memory, intended as the device under test for a memory controller testbench or as a drop-in model inside an FPGA. On every clock edge it samples the pins: a 20-bit address, an active-low chip enable and a combined output-enable/program-supply pin whose level is coded as low, high or high-voltage. A further flag marks the ninth address line as being held at high voltage. From these it derives one of six operating modes and responds on a byte-wide data bus that carries a separate drive-enable.

Cells start erased to all ones. Programming can only pull ones to zeros, so a write stores the bitwise AND of the old and new bytes. A single erase input returns the whole array to the erased state, which stands in for ultraviolet exposure. The full address space is 1,048,576 bytes. The stored array has a parameterised depth, and only the low address bits select a cell, so simulations stay small.

The mode register holds one of six states. STANDBY is entered whenever chip enable is high and the supply pin is not at high voltage. INHIBIT is entered when chip enable is high and the supply pin is at high voltage. OUTOFF is entered when chip enable is low and the pin is high. READ is entered when chip enable is low, the pin is low and the address line is at a normal level. IDENT is entered when chip enable is low, the pin is low and the high-voltage address flag is set. PROGRAM is entered when chip enable is low and the supply pin is at high voltage. Every mode can move to every other mode on the next edge. The transition into PROGRAM from any other mode is the program pulse, and it issues exactly one write strobe.

Top module: `eprom_mode_emu`

## Requirements
- R1: During and after reset, `rdata_oe_o` is 0 and `rdata_o` is 8'h00, and every cell reads back as 8'hFF.
- R2: With chip enable low, the level pin at low (code 2'b00) and no high-voltage address flag, the edge that samples these inputs sets `rdata_oe_o` to 1 and `rdata_o` to the stored byte of the addressed cell.
- R3: With chip enable low and the level pin high (code 2'b01, and the reserved code 2'b11, which is treated as high), the bus is released after the next edge: `rdata_oe_o`=0 and `rdata_o`=8'h00.
- R4: With chip enable high, the bus is released after the next edge whatever the level pin is. With the level pin at high voltage (code 2'b10), nothing is written.
- R5: A program pulse changes the addressed cell to old AND `wdata_i`. The bus stays released while the pulse lasts.
- R6: A program pulse writes exactly once, on the edge where PROGRAM is entered. Later cycles that stay in PROGRAM do not write, even if `wdata_i` changes.
- R7: In IDENT mode the output after the next edge is 8'h20 when address bit 0 is 0 and 8'h42 when it is 1. All other address bits are ignored, and the array is unchanged.
- R8: `erase_all_i` sets every cell to 8'hFF in one edge. It takes priority over a program strobe on the same edge.
- R9: Only the low `DEPTH_LOG2` address bits select a cell. Addresses that differ only in the bits above them reach the same cell for both reading and programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W (20) | Byte address |
| ce_n_i | input | 1 | Active-low chip enable |
| oeprog_lvl_i | input | 2 | Output-enable/program-supply level: 00 low, 01 high, 10 high-voltage, 11 treated as high |
| a9_hv_i | input | 1 | Address line nine held at high voltage |
| erase_all_i | input | 1 | Erase every cell to all ones |
| wdata_i | input | DATA_W (8) | Byte to program |
| rdata_o | output | DATA_W (8) | Output byte, 0 when not driven |
| rdata_oe_o | output | 1 | Drive enable for `rdata_o` |

## Verification
A wrong mode register shows on the drive enable one edge after the pins are sampled. A released bus during a read, or a driven bus in standby, appears at once. A missing or repeated program strobe is hidden until the same cell is read back, so every program pulse is followed by a read that exposes both the AND rule and the single-write rule. A bad identifier decode or a bad address fold shows in the first read that follows. Aliased addresses and the signature toggle on bit 0 are therefore exercised directly.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_HV   = 2'b10,
        LVL_RSVD = 2'b11
    } pin_lvl_e;

    typedef enum logic [2:0] {
        M_STANDBY = 3'd0,
        M_INHIBIT = 3'd1,
        M_OUTOFF  = 3'd2,
        M_READ    = 3'd3,
        M_IDENT   = 3'd4,
        M_PROGRAM = 3'd5
    } mode_e;

    localparam logic [7:0] MFR_CODE   = 8'h20;
    localparam logic [7:0] DEV_CODE   = 8'h42;
    localparam logic [7:0] ERASED_VAL = 8'hFF;

endpackage

// File: rtl/eprom_mode_fsm.sv
module eprom_mode_fsm
    import eprom_emu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic [1:0] lvl,
    input  logic       a9_hv,
    output mode_e      mode_q,
    output mode_e      mode_nxt,
    output logic       wr_strobe
);

    pin_lvl_e lvl_e;
    assign lvl_e = pin_lvl_e'(lvl);

    always_comb begin
        mode_nxt = M_STANDBY;
        if (ce_n) begin
            mode_nxt = (lvl_e == LVL_HV) ? M_INHIBIT : M_STANDBY;
        end else begin
            unique case (lvl_e)
                LVL_HV:  mode_nxt = M_PROGRAM;
                LVL_LOW: mode_nxt = a9_hv ? M_IDENT : M_READ;
                default: mode_nxt = M_OUTOFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= M_STANDBY;
        else        mode_q <= mode_nxt;
    end

    // one strobe per program pulse: only on entry to PROGRAM
    assign wr_strobe = (mode_nxt == M_PROGRAM) && (mode_q != M_PROGRAM);

    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    a_r4_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !wr_strobe);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
    import eprom_emu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  erase,
    input  logic                  wr_en,
    input  logic [DEPTH_LOG2-1:0] idx,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata
);

    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ALL_ONES;
        end else if (wr_en) begin
            mem[idx] <= mem[idx] & wdata;
        end
    end

    assign rdata = mem[idx];

    a_r5_zeros_land: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> ((mem[$past(idx)] & ~$past(wdata)) == '0));

    a_r5_no_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> ((mem[$past(idx)] | $past(rdata)) == $past(rdata)));

    a_r8_erase_all: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem[0] == ALL_ONES && mem[DEPTH-1] == ALL_ONES));

endmodule

// File: rtl/eprom_out_drv.sv
module eprom_out_drv
    import eprom_emu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode_nxt,
    input  logic              a0,
    input  logic [DATA_W-1:0] cell_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            unique case (mode_nxt)
                M_READ: begin
                    rdata    <= cell_data;
                    rdata_oe <= 1'b1;
                end
                M_IDENT: begin
                    rdata    <= a0 ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
                    rdata_oe <= 1'b1;
                end
                default: begin
                    rdata    <= '0;
                    rdata_oe <= 1'b0;
                end
            endcase
        end
    end

    a_r7_ident_code: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_nxt == M_IDENT) |=>
            (rdata_oe && rdata == ($past(a0) ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE))));

    a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

endmodule

// File: rtl/eprom_mode_emu.sv
module eprom_mode_emu
    import eprom_emu_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 8,
    parameter int DEPTH_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic [1:0]        oeprog_lvl_i,
    input  logic              a9_hv_i,
    input  logic              erase_all_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o
);

    mode_e             mode_q;
    mode_e             mode_nxt;
    logic              wr_strobe;
    logic [DATA_W-1:0] cell_rd;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^addr_i[ADDR_W-1:DEPTH_LOG2] ^ ^mode_q;

    eprom_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n_i),
        .lvl       (oeprog_lvl_i),
        .a9_hv     (a9_hv_i),
        .mode_q    (mode_q),
        .mode_nxt  (mode_nxt),
        .wr_strobe (wr_strobe)
    );

    eprom_cell_array #(
        .DATA_W     (DATA_W),
        .DEPTH_LOG2 (DEPTH_LOG2)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase_all_i),
        .wr_en (wr_strobe),
        .idx   (addr_i[DEPTH_LOG2-1:0]),
        .wdata (wdata_i),
        .rdata (cell_rd)
    );

    eprom_out_drv #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_nxt  (mode_nxt),
        .a0        (addr_i[0]),
        .cell_data (cell_rd),
        .rdata     (rdata_o),
        .rdata_oe  (rdata_oe_o)
    );

    a_r4_standby_release: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |=> !rdata_oe_o);

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_i && oeprog_lvl_i == 2'b00) |=> rdata_oe_o);

endmodule

// File: tb/eprom_mode_emu_tb.sv
`timescale 1ns/1ps
module eprom_mode_emu_tb;

    typedef struct {
        bit         chk;
        bit         en;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        ce_n = 1'b1;
    logic [1:0]  lvl = 2'b00;
    logic        a9hv = 1'b0;
    logic        erase = 1'b0;
    logic [7:0]  wdata = 8'hFF;
    logic [7:0]  rdata;
    logic        rdata_oe;

    int n_chk = 0;
    int n_fail = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    eprom_mode_emu u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr),
        .ce_n_i       (ce_n),
        .oeprog_lvl_i (lvl),
        .a9_hv_i      (a9hv),
        .erase_all_i  (erase),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .rdata_oe_o   (rdata_oe)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // driver: apply pins on the falling edge, queue the result due after the next rising edge
    task automatic step(input logic c, input logic [1:0] l, input logic h, input logic [19:0] a,
                        input logic [7:0] d, input logic e, input bit chk, input bit en,
                        input logic [7:0] x, input string tag);
        exp_t it;
        @(negedge clk);
        ce_n = c; lvl = l; a9hv = h; addr = a; wdata = d; erase = e;
        it.chk = chk; it.en = en; it.data = x; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic rd(input logic [19:0] a, input logic [7:0] x, input string tag);
        step(1'b0, 2'b00, 1'b0, a, 8'hFF, 1'b0, 1'b1, 1'b1, x, tag);
    endtask

    task automatic off(input logic c, input logic [1:0] l, input logic [19:0] a, input string tag);
        step(c, l, 1'b0, a, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, tag);
    endtask

    // program pulse: inhibit setup, two cycles low (second with different data), release
    task automatic prog(input logic [19:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 2'b10, 1'b0, a, d, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
        step(1'b0, 2'b10, 1'b0, a, d, 1'b0, 1'b1, 1'b0, 8'h00, tag);
        step(1'b0, 2'b10, 1'b0, a, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R6");
        step(1'b1, 2'b10, 1'b0, a, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
    endtask

    // monitor: sample 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                if (it.chk) begin
                    n_chk++;
                    if (rdata_oe !== it.en || rdata !== it.data) begin
                        n_fail++;
                        $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                                 it.tag, rdata_oe, rdata, it.en, it.data);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (rdata_oe !== 1'b0 || rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R1: got oe=%0b data=%h, expected oe=0 data=00", rdata_oe, rdata);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and erased contents
        off(1'b1, 2'b00, 20'h00005, "R1");
        rd(20'h00005, 8'hFF, "R1");
        rd(20'h0003F, 8'hFF, "R1");

        // R5 / R6 program pulses, then read back
        prog(20'h00005, 8'hA5, "R5");
        rd(20'h00005, 8'hA5, "R5");
        prog(20'h00005, 8'h3C, "R5");
        rd(20'h00005, 8'h24, "R6");

        // R4 inhibit with data on the pins: no write
        step(1'b1, 2'b10, 1'b0, 20'h00007, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
        step(1'b1, 2'b10, 1'b0, 20'h00007, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
        rd(20'h00007, 8'hFF, "R4");

        // R3 output disable, reserved code treated as high
        off(1'b0, 2'b01, 20'h00005, "R3");
        off(1'b0, 2'b11, 20'h00005, "R3");
        // R4 standby with other levels
        off(1'b1, 2'b00, 20'h00005, "R4");
        off(1'b1, 2'b01, 20'h00005, "R4");

        // R9 address folding
        rd(20'hABC45, 8'h24, "R9");
        prog(20'h80007, 8'h0F, "R9");
        rd(20'h00007, 8'h0F, "R9");

        // R2 reads of distinct cells back to back
        rd(20'h00005, 8'h24, "R2");
        rd(20'h00007, 8'h0F, "R2");
        rd(20'h00006, 8'hFF, "R2");

        // R7 identifier codes, upper address bits ignored
        step(1'b0, 2'b00, 1'b1, 20'h00000, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h20, "R7");
        step(1'b0, 2'b00, 1'b1, 20'h00001, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h42, "R7");
        step(1'b0, 2'b00, 1'b1, 20'hFFFFE, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h20, "R7");
        step(1'b0, 2'b00, 1'b1, 20'h00005, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h42, "R7");
        rd(20'h00005, 8'h24, "R7");

        // R8 erase, and erase beating a concurrent program entry
        step(1'b1, 2'b00, 1'b0, 20'h00000, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00, "R8");
        rd(20'h00005, 8'hFF, "R8");
        rd(20'h00007, 8'hFF, "R8");
        step(1'b0, 2'b10, 1'b0, 20'h00009, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, "R8");
        step(1'b1, 2'b00, 1'b0, 20'h00009, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
        rd(20'h00009, 8'hFF, "R8");

        step(1'b1, 2'b00, 1'b0, 20'h00000, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, "idle");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule